// File: doc/BRIEF.md
# Bipolar Serial Word Transmitter with Queue

The block takes 32-bit avionics data words from a 16-bit host port and sends them on a two-wire three-level return-to-zero line. The host writes the lower half of a word with one strobe and the upper half with a second strobe. The second strobe places the completed word in a 16-entry first-in-first-out queue.

A transmit-enable input controls the queue. While the input is low the host can fill the queue and nothing is sent. While it is high, queued words go out one after another, with a null gap between consecutive words. The top bit of every word is replaced by a parity bit. Odd or even parity is selected by an input.

Each bit occupies two half-bit periods. For a one, the high wire is driven in the first half and both wires are null in the second half. For a zero, the low wire is driven in the first half and both wires are null in the second half. The half-bit length is selected between a fast rate and a slow rate that is eight times longer. These correspond to 100 kbps and 12.5 kbps when the clock is scaled accordingly.

Top module: `a429q_tx`

## Requirements
- R1: A pulse on `loadLow` stores `hostData` as bits 15..0 of a pending word. A later `loadLow` overwrites that stored half. A pulse on `loadHigh` enqueues the word formed by `hostData` as bits 31..16 and the stored lower half.
- R2: The queue holds up to 16 words and transmits them in the order they were enqueued.
- R3: `fifoFull` is high while 16 words are queued. `fifoEmpty` is high while none are queued. Either load strobe that arrives while `fifoFull` is high is ignored: no word is added, and nothing that was stored is changed.
- R4: No word starts while `txEnable` is low. A word already in progress when `txEnable` falls is sent completely, followed by its gap.
- R5: Each word is sent in the following serial order:
  - bits 7, 6, …, 0 first (label, most significant first);
  - then bits 8 through 30 in rising order;
  - then the parity bit last.
- R6: The host's bit 31 is discarded. When `parityEven` is 0, the sent bit 31 makes the total count of ones in the 32 sent bits odd. When `parityEven` is 1, it makes the count even. `parityEven` is sampled when a word starts.
- R7: For a one bit, `lineHi` is 1 and `lineLo` is 0 for the first half-bit, then both are 0 for the second half. For a zero bit, `lineLo` is 1 and `lineHi` is 0 for the first half, then both are 0. Both outputs are never 1 together, and both are 0 when no word is being sent.
- R8: With `rateSlow` = 0, a half-bit lasts HALF_FAST clocks (default 4). With `rateSlow` = 1, it lasts HALF_FAST×SLOW_MULT clocks (default 32). `rateSlow` is sampled when a word starts and held for the whole word.
- R9: After the last bit of a word, both outputs stay null for GAP_BITS (default 4) bit times. The next word can begin one clock after that gap ends.
- R10: While `rstN` is low, the queue is emptied: `fifoEmpty` is 1, `fifoFull` is 0, and both line outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostData | input | 16 | Host half-word |
| loadLow | input | 1 | Strobe: store lower half |
| loadHigh | input | 1 | Strobe: store upper half and enqueue the word |
| txEnable | input | 1 | Allows queued words to be sent |
| parityEven | input | 1 | 1 = even parity, 0 = odd parity |
| rateSlow | input | 1 | 1 = slow rate, 0 = fast rate |
| lineHi | output | 1 | Drives the line high (one bits) |
| lineLo | output | 1 | Drives the line low (zero bits) |
| fifoEmpty | output | 1 | Queue holds no words |
| fifoFull | output | 1 | Queue holds 16 words |

## Verification
Internal faults show up at the ports as follows:
- A wrong queue pointer or occupancy count shows as a word sent out of order, a duplicated or missing word, or a flag edge one word early or late. This is visible no later than the first bit of the affected word.
- A fault in the sequencer's half-bit or gap counting shifts the line pulses in time. The bench samples each half-bit at its centre and checks every gap cycle, so a one-clock error is caught within the same word.
- A wrong bit order or parity shows as a wrong first-half level on a specific bit position. The bench sweeps all 16 queue slots, both parity modes and both rates.

// File: rtl/a429q_pkg.sv
package a429q_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BITS = 2'd1,
    SEQ_GAP  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchLow;   // capture lower half
    logic pushWord;   // write completed word at wrPtr
    logic loadShift;  // load head word into serializer
    logic shiftBit;   // advance serializer by one bit
    logic driveLine;  // first half of a bit: put current bit on the line
  } txStrobe_t;
endpackage

// File: rtl/a429q_datapath.sv
module a429q_datapath
  import a429q_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [15:0]      hostData,
  input  logic             parityEven,
  input  txStrobe_t        strobe,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  output logic             lineHi,
  output logic             lineLo
);
  logic [15:0] lowHalf;
  logic [31:0] store [DEPTH];
  logic [31:0] shiftReg;

  // reorder into serial order: label MSB first, then bits 8..30, parity last
  function automatic logic [31:0] serialOrder(input logic [31:0] w, input logic evenPar);
    logic [31:0] r;
    for (int k = 0; k < 8; k++) r[k] = w[7-k];
    r[30:8] = w[30:8];
    r[31]   = evenPar ? (^w[30:0]) : ~(^w[30:0]);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) lowHalf <= '0;
    else if (strobe.latchLow) lowHalf <= hostData;
  end

  always_ff @(posedge clk) begin
    if (strobe.pushWord) store[wrPtr] <= {hostData, lowHalf};
  end

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.loadShift) shiftReg <= serialOrder(store[rdPtr], parityEven);
    else if (strobe.shiftBit) shiftReg <= {1'b0, shiftReg[31:1]};
  end

  assign lineHi = strobe.driveLine & shiftReg[0];
  assign lineLo = strobe.driveLine & ~shiftReg[0];

  // a loaded word puts a level on the line on the very next cycle
  AST_LOAD_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadShift |=> (lineHi || lineLo)); // R7
endmodule

// File: rtl/a429q_ctrl.sv
module a429q_ctrl
  import a429q_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int HALF_FAST = 4,
  parameter int SLOW_MULT = 8,
  parameter int GAP_BITS  = 4,
  parameter int WORD_BITS = 32,
  localparam int PTR_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadLow,
  input  logic             loadHigh,
  input  logic             txEnable,
  input  logic             rateSlow,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output txStrobe_t        strobe
);
  localparam int CNT_W     = $clog2(DEPTH + 1);
  localparam int HALF_SLOW = HALF_FAST * SLOW_MULT;
  localparam int PH_W      = $clog2(HALF_SLOW);
  localparam int BIT_W     = $clog2(WORD_BITS);
  localparam int GAP_HALVES = 2 * GAP_BITS;
  localparam int GH_W      = $clog2(GAP_HALVES);

  seqState_t        stateQ;
  logic [CNT_W-1:0] count;
  logic [PH_W-1:0]  phaseCnt;
  logic             halfSel;
  logic [BIT_W-1:0] bitIdx;
  logic [GH_W-1:0]  gapHalf;
  logic             slowQ;
  logic             accept, startWord, halfEnd;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign accept    = loadHigh && !fifoFull;
  assign startWord = (stateQ == SEQ_IDLE) && txEnable && !fifoEmpty;
  assign halfEnd   = phaseCnt == (slowQ ? PH_W'(HALF_SLOW - 1) : PH_W'(HALF_FAST - 1));

  always_comb begin
    strobe.latchLow  = loadLow && !fifoFull;
    strobe.pushWord  = accept;
    strobe.loadShift = startWord;
    strobe.shiftBit  = (stateQ == SEQ_BITS) && halfEnd && halfSel;
    strobe.driveLine = (stateQ == SEQ_BITS) && !halfSel;
  end

  // queue bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      count <= count + CNT_W'(accept) - CNT_W'(startWord);
      if (accept)    wrPtr <= bump(wrPtr);
      if (startWord) rdPtr <= bump(rdPtr);
    end
  end

  // bit sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= SEQ_IDLE;
      phaseCnt <= '0;
      halfSel  <= 1'b0;
      bitIdx   <= '0;
      gapHalf  <= '0;
      slowQ    <= 1'b0;
    end else begin
      unique case (stateQ)
        SEQ_IDLE: begin
          if (startWord) begin
            stateQ   <= SEQ_BITS;
            phaseCnt <= '0;
            halfSel  <= 1'b0;
            bitIdx   <= '0;
            slowQ    <= rateSlow;
          end
        end
        SEQ_BITS: begin
          if (halfEnd) begin
            phaseCnt <= '0;
            halfSel  <= ~halfSel;
            if (halfSel) begin
              bitIdx <= bitIdx + 1'b1;
              if (bitIdx == BIT_W'(WORD_BITS - 1)) begin
                stateQ  <= SEQ_GAP;
                gapHalf <= '0;
              end
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        SEQ_GAP: begin
          if (halfEnd) begin
            phaseCnt <= '0;
            gapHalf  <= gapHalf + 1'b1;
            if (gapHalf == GH_W'(GAP_HALVES - 1)) stateQ <= SEQ_IDLE;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: stateQ <= SEQ_IDLE;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R3
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !startWord) |=> fifoFull); // R3
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SEQ_IDLE && !txEnable) |=> (stateQ != SEQ_BITS)); // R4
  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SEQ_BITS && $past(stateQ) == SEQ_BITS) |-> $stable(slowQ)); // R8
  AST_GAP_AFTER_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SEQ_BITS) |=> (stateQ != SEQ_IDLE)); // R9
endmodule

// File: rtl/a429q_tx.sv
module a429q_tx
  import a429q_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int HALF_FAST = 4,
  parameter int SLOW_MULT = 8,
  parameter int GAP_BITS  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] hostData,
  input  logic        loadLow,
  input  logic        loadHigh,
  input  logic        txEnable,
  input  logic        parityEven,
  input  logic        rateSlow,
  output logic        lineHi,
  output logic        lineLo,
  output logic        fifoEmpty,
  output logic        fifoFull
);
  localparam int PTR_W = $clog2(DEPTH);

  txStrobe_t        strobe;
  logic [PTR_W-1:0] wrPtr, rdPtr;

  a429q_ctrl #(
    .DEPTH(DEPTH), .HALF_FAST(HALF_FAST), .SLOW_MULT(SLOW_MULT),
    .GAP_BITS(GAP_BITS), .WORD_BITS(32)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .loadLow(loadLow), .loadHigh(loadHigh),
    .txEnable(txEnable), .rateSlow(rateSlow), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .wrPtr(wrPtr), .rdPtr(rdPtr), .strobe(strobe)
  );

  a429q_datapath #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .hostData(hostData), .parityEven(parityEven),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .lineHi(lineHi), .lineLo(lineLo)
  );

  AST_NO_BOTH_LINES: assert property (@(posedge clk) disable iff (!rstN)
    !(lineHi && lineLo)); // R7
  AST_HALF_MIN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineHi) |=> lineHi); // R8
endmodule

// File: tb/a429q_tx_bench.sv
module a429q_tx_bench;
  localparam int HF = 4;
  localparam int HS = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] hostData = '0;
  logic loadLow = 1'b0, loadHigh = 1'b0, txEnable = 1'b0;
  logic parityEven = 1'b0, rateSlow = 1'b0;
  logic lineHi, lineLo, fifoEmpty, fifoFull;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  a429q_tx u_a429q_tx (
    .clk(clk), .rstN(rstN), .hostData(hostData), .loadLow(loadLow),
    .loadHigh(loadHigh), .txEnable(txEnable), .parityEven(parityEven),
    .rateSlow(rateSlow), .lineHi(lineHi), .lineLo(lineLo),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadWord(input logic [31:0] w);
    @(negedge clk); hostData = w[15:0]; loadLow = 1'b1;
    @(negedge clk); loadLow = 1'b0; hostData = w[31:16]; loadHigh = 1'b1;
    @(negedge clk); loadHigh = 1'b0;
  endtask

  function automatic logic [31:0] pattern(input int i);
    return (32'h9E3779B9 * 32'(i + 1)) ^ (32'(i) << 24);
  endfunction

  // expected serial bit k of a word
  function automatic logic expBit(input logic [31:0] w, input int k, input logic even);
    int ones = 0;
    for (int j = 0; j < 31; j++) ones += int'(w[j]);
    if (k < 8) return w[7 - k];
    if (k < 31) return w[k];
    return even ? logic'(ones % 2) : logic'(1 - ones % 2);
  endfunction

  // wait for a word, check every bit half and the gap that follows
  task automatic recvWord(input logic [31:0] w, input logic even, input logic slow, input bit dropEn);
    int h = slow ? HS : HF;
    int n = 0;
    int waitCnt = 0;
    int badBits = 0;
    int badGap = 0;
    @(negedge clk);
    while (!(lineHi || lineLo) && waitCnt < 5000) begin
      @(negedge clk); waitCnt++;
    end
    chk("R4 word start seen", 32'(waitCnt < 5000), 32'd1);
    if (dropEn) txEnable = 1'b0;
    for (int k = 0; k < 32; k++) begin
      logic b = expBit(w, k, even);
      while (n < k * 2 * h + h / 2) begin @(negedge clk); n++; end
      if (lineHi !== b || lineLo !== !b) begin
        badBits++;
        $display("FAIL R5/R6/R7 bit %0d of %h: actual hi=%b lo=%b expected hi=%b lo=%b",
                 k, w, lineHi, lineLo, b, !b);
      end
      while (n < k * 2 * h + h + h / 2) begin @(negedge clk); n++; end
      if (lineHi !== 1'b0 || lineLo !== 1'b0) begin
        badBits++;
        $display("FAIL R7/R8 null half of bit %0d: actual hi=%b lo=%b expected 0 0", k, lineHi, lineLo);
      end
    end
    nChecks++;
    if (badBits != 0) nFail++;
    while (n < 64 * h) begin @(negedge clk); n++; end
    for (int g = 0; g < 8 * h; g++) begin
      if (lineHi || lineLo) badGap++;
      @(negedge clk); n++;
    end
    chk("R9 gap null cycles", 32'(badGap), 32'd0);
  endtask

  task automatic quietFor(input int cycles, input string req);
    int act = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (lineHi || lineLo) act++;
    end
    chk(req, 32'(act), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 empty in reset", 32'(fifoEmpty), 32'd1);
    chk("R10 full in reset", 32'(fifoFull), 32'd0);
    chk("R10 lines null", 32'({lineHi, lineLo}), 32'd0);
    rstN = 1'b1;

    // fill all 16 slots with transmit disabled
    for (int i = 0; i < 16; i++) begin
      loadWord(pattern(i));
      if (i == 14) chk("R3 not full at 15", 32'(fifoFull), 32'd0);
    end
    chk("R3 full at 16", 32'(fifoFull), 32'd1);
    chk("R3 not empty", 32'(fifoEmpty), 32'd0);
    quietFor(100, "R4 nothing sent while disabled");
    loadWord(32'hFFFF_FFFF);           // R3 ignored while full
    chk("R3 full after ignored load", 32'(fifoFull), 32'd1);

    // drain in order, odd parity, fast rate
    txEnable = 1'b1;
    for (int i = 0; i < 16; i++) begin
      recvWord(pattern(i), 1'b0, 1'b0, 1'b0);
      if (i == 0) chk("R3 full drops after first pop", 32'(fifoFull), 32'd0);
    end
    quietFor(200, "R2 no extra word after 16");
    chk("R2 empty after drain", 32'(fifoEmpty), 32'd1);

    // R1 lower half overwrite, even parity, edge patterns
    txEnable = 1'b0;
    parityEven = 1'b1;
    @(negedge clk); hostData = 16'h1111; loadLow = 1'b1;
    @(negedge clk); hostData = 16'h00A5;
    @(negedge clk); loadLow = 1'b0; hostData = 16'h8C3E; loadHigh = 1'b1;
    @(negedge clk); loadHigh = 1'b0;
    loadWord(32'h0000_0000);
    loadWord(32'h7FFF_FFFF);
    txEnable = 1'b1;
    recvWord(32'h8C3E_00A5, 1'b1, 1'b0, 1'b0);   // R1
    recvWord(32'h0000_0000, 1'b1, 1'b0, 1'b0);   // R6
    recvWord(32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0);   // R6

    // R8 slow rate, odd parity
    txEnable = 1'b0;
    parityEven = 1'b0;
    rateSlow = 1'b1;
    loadWord(32'hC0DE_5A81);
    loadWord(32'h0123_4567);
    txEnable = 1'b1;
    recvWord(32'hC0DE_5A81, 1'b0, 1'b1, 1'b0);
    recvWord(32'h0123_4567, 1'b0, 1'b1, 1'b0);

    // R4 enable dropped during a word
    txEnable = 1'b0;
    rateSlow = 1'b0;
    loadWord(32'hDEAD_BEEF);
    loadWord(32'h3C3C_F00F);
    txEnable = 1'b1;
    recvWord(32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1);
    quietFor(300, "R4 no start after enable low");
    chk("R4 word still queued", 32'(fifoEmpty), 32'd0);
    txEnable = 1'b1;
    recvWord(32'h3C3C_F00F, 1'b0, 1'b0, 1'b0);
    chk("R2 empty at end", 32'(fifoEmpty), 32'd1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule